// File: doc/BRIEF.md
# Level-Crossing Sample Timestamping Controller

This block is the digital heart of a level-crossing converter. Two external comparators tell it when the analog input has moved a full quantum above or below the reconstructed reference. The block keeps the current quantized level in an up/down register and drives that level to an external DAC as a thermometer code. It times the gap between samples with a local interval counter that advances on a tick enable, which stands in for the timer clock of period TC.

Every accepted level change produces one output sample. A sample is a pair: the new level and the number of ticks since the previous sample. When the input stays quiet long enough for the counter to reach its top value, the block still emits a sample. That sample carries the unchanged level and the largest interval.

Samples leave over a four-phase request/acknowledge channel. The step inputs form the incoming stream, with `step_ready` as their back-pressure. While a transfer is in flight, `step_ready` is low and step indications are not consumed. A comparator that keeps its indication asserted is served as soon as the channel returns to idle, so no crossing is lost.

Top module: `lcts_core`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, the level is 0, `dac_thermo` is all zeros, `step_ready` is 1 and `smp_req` is 0.
- R2: In a cycle with `step_ready` high, `step_up` alone raises the level by one and `step_dn` alone lowers it by one. The sample then presented on `smp_level` is the new level.
- R3: The level stays within 0 to 2^LVL_W−2, which is 0 to 14 by default. An up step at the top or a down step at 0 leaves the level unchanged and emits no sample.
- R4: When both step inputs are high, or both are low, the level does not change and no step sample is emitted.
- R5: `smp_ticks` equals the number of cycles with `tick_en` high since the previous emission. The counter restarts from zero in the emission cycle, and a tick in that same cycle is not counted.
- R6: When the counter holds 2^TMR_W−1 (4095 by default) and `step_ready` is high with no accepted step, a sample is emitted with the unchanged level and `smp_ticks` all ones. The counter saturates at that value and never wraps.
- R7: Bit k of `dac_thermo` (width 2^LVL_W−1, bit 0 the lowest) is 1 exactly when k is less than the level.
- R8: `smp_req` rises on the clock edge that accepts an event. Level and ticks stay stable while `smp_req` is high. `smp_req` falls on the edge that sees `smp_ack` high. The channel goes back to idle on the edge that sees `smp_ack` low.
- R9: `step_ready` is low from an emission until the channel is idle again. Step inputs seen while it is low leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of level, timer and channel |
| tick_en | input | 1 | One timer period elapsed this cycle |
| step_up | input | 1 | Upper comparator: input above reference |
| step_dn | input | 1 | Lower comparator: input below reference |
| step_ready | output | 1 | Step inputs are consumed this cycle |
| dac_thermo | output | 2^LVL_W−1 | Thermometer code of the level for the DAC |
| smp_req | output | 1 | Four-phase request: a sample is presented |
| smp_ack | input | 1 | Four-phase acknowledge from the consumer |
| smp_level | output | LVL_W | Level carried by the sample |
| smp_ticks | output | TMR_W | Ticks since the previous sample |

## Verification
Each result is due one edge after the inputs that cause it. An accepted step moves the level and `dac_thermo`, raises `smp_req`, loads the sample fields and drops `step_ready`, all on that single edge. An acknowledge edge changes the channel state on the next edge. The bench drives inputs just after a falling edge and compares every output at the following falling edge. It checks against a cycle model advanced once per rising edge from the same inputs, so every comparison lands exactly one register stage after its cause. Long quiet stretches with `tick_en` held high bring the counter to its top value, so the overflow sample is reached and compared cycle-exactly as well.

// File: rtl/lcts_pkg.sv
package lcts_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_HOLD  = 2'd1,
    HS_DRAIN = 2'd2
  } hs_state_e;
endpackage

// File: rtl/lcts_level.sv
module lcts_level #(
  parameter int LVL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    up_i,
  input  logic                    dn_i,
  output logic                    step_o,
  output logic [LVL_W-1:0]        lvl_o,
  output logic [LVL_W-1:0]        lvl_nx_o,
  output logic [(1<<LVL_W)-2:0]   thermo_o
);
  localparam int NTH  = (1 << LVL_W) - 1;
  localparam int LTOP = (1 << LVL_W) - 2;

  logic [LVL_W-1:0] lvl_q;
  logic go_up, go_dn;

  assign go_up  = en_i & up_i & ~dn_i & (lvl_q != LTOP[LVL_W-1:0]);
  assign go_dn  = en_i & dn_i & ~up_i & (lvl_q != '0);
  assign step_o = go_up | go_dn;

  always_comb begin
    lvl_nx_o = lvl_q;
    if (go_up)      lvl_nx_o = lvl_q + LVL_W'(1);
    else if (go_dn) lvl_nx_o = lvl_q - LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_nx_o;
  end

  assign lvl_o = lvl_q;

  for (genvar g = 0; g < NTH; g++) begin : g_thermo
    assign thermo_o[g] = (int'(lvl_q) > g);
  end

  // R2: the level never jumps by more than one step
  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |->
      (lvl_q == $past(lvl_q) + LVL_W'(1) || lvl_q == $past(lvl_q) - LVL_W'(1)));

  // R3: the level stays inside its range
  assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lvl_q) <= LTOP);

  // R7: the count of ones in the DAC code tracks the level
  assert_thermo_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(thermo_o) == int'(lvl_q));
endmodule

// File: rtl/lcts_timer.sv
module lcts_timer #(
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             full_o
);
  logic [TMR_W-1:0] cnt_q;

  assign full_o = &cnt_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (tick_i && !full_o) cnt_q <= cnt_q + TMR_W'(1);
  end

  // R6: a full counter holds until it is cleared
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !clr_i) |=> full_o);

  // R5: the counter advances only on a tick
  assert_tick_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lcts_handshake.sv
module lcts_handshake
  import lcts_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [TMR_W-1:0] ticks_i,
  input  logic             ack_i,
  output logic             ready_o,
  output logic             req_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [TMR_W-1:0] ticks_o
);
  hs_state_e        st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [TMR_W-1:0] ticks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HS_IDLE;
      lvl_q   <= '0;
      ticks_q <= '0;
    end else begin
      case (st_q)
        HS_IDLE:  if (load_i) begin
                    st_q    <= HS_HOLD;
                    lvl_q   <= lvl_i;
                    ticks_q <= ticks_i;
                  end
        HS_HOLD:  if (ack_i)  st_q <= HS_DRAIN;
        HS_DRAIN: if (!ack_i) st_q <= HS_IDLE;
        default:  st_q <= HS_IDLE;
      endcase
    end
  end

  assign ready_o = (st_q == HS_IDLE);
  assign req_o   = (st_q == HS_HOLD);
  assign lvl_o   = lvl_q;
  assign ticks_o = ticks_q;

  // R8: request and data hold until acknowledged
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(lvl_q) && $stable(ticks_q)));

  // R8: request drops after acknowledge is seen
  assert_req_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> !req_o);

  // R9: no new transfer starts before acknowledge returns low
  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !req_o && ack_i) |=> !ready_o);
endmodule

// File: rtl/lcts_core.sv
module lcts_core #(
  parameter int LVL_W = 4,
  parameter int TMR_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  step_up,
  input  logic                  step_dn,
  output logic                  step_ready,
  output logic [(1<<LVL_W)-2:0] dac_thermo,
  output logic                  smp_req,
  input  logic                  smp_ack,
  output logic [LVL_W-1:0]      smp_level,
  output logic [TMR_W-1:0]      smp_ticks
);
  logic             step, full, emit;
  logic [LVL_W-1:0] lvl, lvl_nx;
  logic [TMR_W-1:0] cnt;

  lcts_level #(.LVL_W(LVL_W)) u_level (
    .clk(clk), .rst_n(rst_n), .en_i(step_ready), .up_i(step_up), .dn_i(step_dn),
    .step_o(step), .lvl_o(lvl), .lvl_nx_o(lvl_nx), .thermo_o(dac_thermo)
  );

  assign emit = step_ready & (step | full);

  lcts_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .clr_i(emit),
    .cnt_o(cnt), .full_o(full)
  );

  lcts_handshake #(.LVL_W(LVL_W), .TMR_W(TMR_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .load_i(emit), .lvl_i(lvl_nx), .ticks_i(cnt),
    .ack_i(smp_ack), .ready_o(step_ready), .req_o(smp_req),
    .lvl_o(smp_level), .ticks_o(smp_ticks)
  );

  // R9: the level is frozen while the channel is busy
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step_ready |=> $stable(lvl));

  // R6: a quiet full counter produces a maximum-interval sample
  assert_ovf_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ready && full && !step) |=> (smp_req && (&smp_ticks) && smp_level == $past(lvl)));

  // R2: an accepted step is presented with its new level
  assert_step_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ready && step) |=> (smp_req && smp_level == lvl));
endmodule

// File: tb/lcts_core_bench.sv
`timescale 1ns/1ps
module lcts_core_bench;
  localparam int LVL_W = 4;
  localparam int TMR_W = 12;
  localparam int NTH   = (1 << LVL_W) - 1;
  localparam int LTOP  = (1 << LVL_W) - 2;
  localparam int CMAX  = (1 << TMR_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, step_up = 1'b0, step_dn = 1'b0, smp_ack = 1'b0;
  logic step_ready, smp_req;
  logic [NTH-1:0] dac_thermo;
  logic [LVL_W-1:0] smp_level;
  logic [TMR_W-1:0] smp_ticks;

  always #2.5 clk = ~clk;

  lcts_core #(.LVL_W(LVL_W), .TMR_W(TMR_W)) u_lcts_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .step_up(step_up), .step_dn(step_dn),
    .step_ready(step_ready), .dac_thermo(dac_thermo), .smp_req(smp_req),
    .smp_ack(smp_ack), .smp_level(smp_level), .smp_ticks(smp_ticks)
  );

  int n_chk = 0, n_bad = 0, n_emit = 0, n_ovf = 0;
  bit done = 1'b0;
  int mlev = 0, mcnt = 0, mst = 0, mout_lv = 0, mout_tk = 0;
  int ack_pct = 50;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int thermo_of(input int lv);
    int v = 0;
    for (int k = 0; k < NTH; k++) if (k < lv) v |= (1 << k);
    return v;
  endfunction

  task automatic compare_outputs();
    chk(step_ready == (mst == 0), "R9 ready", int'(step_ready), int'(mst == 0));
    chk(smp_req == (mst == 1), "R8 req", int'(smp_req), int'(mst == 1));
    chk(int'(dac_thermo) == thermo_of(mlev), "R7 thermo", int'(dac_thermo), thermo_of(mlev));
    if (mst == 1) begin
      chk(int'(smp_level) == mout_lv, "R2 level", int'(smp_level), mout_lv);
      chk(int'(smp_ticks) == mout_tk, "R5 ticks", int'(smp_ticks), mout_tk);
    end
  endtask

  // one cycle: outputs checked at negedge, inputs applied, model advanced
  task automatic cycle(input bit up, input bit dn, input bit tk);
    bit rdy, stp, ovf;
    compare_outputs();
    if (mst == 1 && !smp_ack && ($urandom % 100) < ack_pct) smp_ack = 1'b1;
    else if (mst != 1 && smp_ack && ($urandom % 100) < ack_pct) smp_ack = 1'b0;
    step_up = up; step_dn = dn; tick_en = tk;
    rdy = (mst == 0);
    stp = rdy && (up != dn) && (up ? (mlev < LTOP) : (mlev > 0));
    ovf = rdy && !stp && (mcnt == CMAX);
    if (stp) mlev = up ? mlev + 1 : mlev - 1;
    if (stp || ovf) begin
      mout_lv = mlev; mout_tk = mcnt; mcnt = 0; n_emit++;
      if (ovf) n_ovf++;
    end else if (tk && mcnt < CMAX) mcnt++;
    case (mst)
      0: if (stp || ovf) mst = 1;
      1: if (smp_ack) mst = 2;
      default: if (!smp_ack) mst = 0;
    endcase
    @(posedge clk); @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int e0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(step_ready == 1'b1, "R1 ready", int'(step_ready), 1);
    chk(smp_req == 1'b0, "R1 req", int'(smp_req), 0);
    chk(dac_thermo == '0, "R1 thermo", int'(dac_thermo), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_thermo == '0 && step_ready, "R1 after release", int'(dac_thermo), 0);

    // R2/R3: climb past the top with fast acknowledge
    ack_pct = 100;
    for (int i = 0; i < 80; i++) cycle(1'b1, 1'b0, 1'b1);
    chk(mlev == LTOP, "R3 model top", mlev, LTOP);
    chk($countones(dac_thermo) == LTOP, "R3 level at top", $countones(dac_thermo), LTOP);
    e0 = n_emit;
    for (int i = 0; i < 30; i++) cycle(1'b1, 1'b0, 1'b0);
    chk(n_emit == e0, "R3 no sample at top", n_emit - e0, 0);
    chk(smp_req == 1'b0, "R3 req idle at top", int'(smp_req), 0);

    // R4: both asserted, then neither
    e0 = n_emit;
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 1'b0);
    chk(n_emit == e0, "R4 no sample", n_emit - e0, 0);
    chk($countones(dac_thermo) == LTOP, "R4 level held", $countones(dac_thermo), LTOP);

    // R3: descend past the bottom with slow acknowledge (R9 stall)
    ack_pct = 20;
    for (int i = 0; i < 200; i++) cycle(1'b0, 1'b1, 1'b1);
    chk(dac_thermo == '0, "R3 level at bottom", int'(dac_thermo), 0);

    // R6: quiet input, ticks every cycle, until two overflow samples
    ack_pct = 60;
    e0 = n_ovf;
    for (int i = 0; i < 8400; i++) cycle(1'b0, 1'b0, 1'b1);
    chk(n_ovf - e0 >= 2, "R6 overflow samples", n_ovf - e0, 2);
    chk(dac_thermo == '0, "R6 level unchanged", int'(dac_thermo), 0);

    // R5/R8: random mix of steps, ticks and acknowledge latency
    for (int i = 0; i < 30000; i++) begin
      int r = $urandom % 16;
      ack_pct = 10 + ($urandom % 80);
      cycle(r < 3, r >= 3 && r < 6, ($urandom % 4) != 0);
    end
    // quiet sparse ticks to reach overflow under random tick gaps
    e0 = n_ovf;
    for (int i = 0; i < 9000; i++) cycle(1'b0, 1'b0, ($urandom % 8) != 0);
    chk(n_ovf > e0, "R6 overflow with gaps", n_ovf - e0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule